// File: doc/BRIEF.md
# Masked Circular Buffer Address Generator

This block holds one data address and moves it forward after each access by a small step (1, 2 or 4 bytes). A mask register marks the low address bits that form the offset inside a circular buffer. When the address advances, the sum is kept only in the marked bits, so any carry out of the marked field is dropped. The address therefore wraps back to the start of the buffer instead of running past its end, and the bits above the field stay at the buffer base. Because the wrap comes from discarding that carry rather than from comparing against an end address, a wrapping step takes the same single cycle as any other step.

The buffer size is a power of two (mask = size - 1, a run of ones from bit 0) and the buffer is aligned to its size. A zero mask turns the block into a plain linear post-increment address register. A step that cannot fit in the buffer, or an undefined step code, is reported on an error output for that access, and the address does not move.

Top module: `circ_addr_gen`

## Requirements
- R1: When `addr_ld_i` is high at a clock edge, `addr_o` equals `addr_i` after that edge; a load takes priority over `adv_i` in the same cycle.
- R2: When `mask_ld_i` is high, `mask_i` becomes the active mask after that edge; an advance in the same cycle still uses the previous mask.
- R3: Step code `step_i` selects the advance: 2'b00 = 1 byte, 2'b01 = 2 bytes, 2'b10 = 4 bytes.
- R4: With a non-zero mask, an advance writes the bits of (address + step) only where the mask bit is 1; all other address bits, including every bit at or above position 16, keep their value, so the offset wraps modulo the buffer size.
- R5: With a zero mask, an advance adds the step over the full address width, wrapping modulo 2^32.
- R6: With `adv_i` and `addr_ld_i` both low, `addr_o` keeps its value.
- R7: An advance with step code 2'b11, or with a non-zero mask whose buffer size (mask + 1) is smaller than the step, raises `step_err_o` for the cycle after that edge only and leaves `addr_o` unchanged.
- R8: Advances on consecutive cycles each move the address, including the cycle that wraps; no cycle is lost on a wrap.
- R9: After synchronous reset, `addr_o` is 0, the mask is 0 and `step_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_ld_i | input | 1 | Load `addr_i` into the address register |
| addr_i | input | 32 | Address to load |
| mask_ld_i | input | 1 | Load `mask_i` into the mask register |
| mask_i | input | 16 | Circular field mask (size - 1), zero for linear mode |
| adv_i | input | 1 | Post-increment the address by the selected step |
| step_i | input | 2 | Step code: 00 = 1, 01 = 2, 10 = 4, 11 = undefined |
| addr_o | output | 32 | Current address, registered |
| step_err_o | output | 1 | Registered flag for an advance with a bad or oversize step |

## Verification
A corrupted mask register shows up at the very next advance as a wrong offset or a disturbed upper address bit, so the per-clock comparison against the bench model catches it within one cycle of use. A wrong carry cut appears on the first advance that crosses the buffer end, which the bench places directly after each mask load with offsets a step or two from the end. A stuck or mis-decoded error flag shows on the same edge as the offending advance, together with an address that moved when it should have held.

// File: rtl/cag_pkg.sv
package cag_pkg;

  typedef enum logic [1:0] {
    STEP_B1  = 2'b00,
    STEP_B2  = 2'b01,
    STEP_B4  = 2'b10,
    STEP_BAD = 2'b11
  } step_code_e;

  localparam int STEP_W = 3;

endpackage

// File: rtl/cag_step_dec.sv
module cag_step_dec
  import cag_pkg::*;
(
  input  logic [1:0]        code_i,
  output logic [STEP_W-1:0] bytes_o,
  output logic              bad_o
);

  always_comb begin
    bad_o = 1'b0;
    unique case (step_code_e'(code_i))
      STEP_B1: bytes_o = STEP_W'(1);
      STEP_B2: bytes_o = STEP_W'(2);
      STEP_B4: bytes_o = STEP_W'(4);
      default: begin
        bytes_o = '0;
        bad_o   = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/cag_wrap_add.sv
module cag_wrap_add
  import cag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [ADDR_W-1:0] next_o,
  output logic              oversize_o
);

  localparam int CMP_W = MASK_W + 1;

  logic              linear;
  logic [ADDR_W-1:0] sum;
  logic [CMP_W-1:0]  buf_size;

  assign linear     = (mask_i == '0);
  assign sum        = addr_i + {{(ADDR_W-STEP_W){1'b0}}, step_i};
  assign buf_size   = {1'b0, mask_i} + CMP_W'(1);
  assign oversize_o = !linear && (buf_size < {{(CMP_W-STEP_W){1'b0}}, step_i});

  // Carry cut: a bit takes the sum only inside the mask field.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i < MASK_W) begin : g_field
      assign next_o[i] = (linear || mask_i[i]) ? sum[i] : addr_i[i];
    end else begin : g_base
      assign next_o[i] = linear ? sum[i] : addr_i[i];
    end
  end

endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import cag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mask_ld_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              adv_i,
  input  logic [1:0]        step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              step_err_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [MASK_W-1:0] mask_q;
  logic              err_q;
  logic [STEP_W-1:0] step_bytes;
  logic              step_bad;
  logic [ADDR_W-1:0] addr_next;
  logic              oversize;
  logic              adv_req;
  logic              adv_fault;
  logic [ADDR_W-1:0] mask_ext;

  cag_step_dec i_dec (
    .code_i  (step_i),
    .bytes_o (step_bytes),
    .bad_o   (step_bad)
  );

  cag_wrap_add #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) i_add (
    .addr_i     (addr_q),
    .mask_i     (mask_q),
    .step_i     (step_bytes),
    .next_o     (addr_next),
    .oversize_o (oversize)
  );

  assign adv_req   = adv_i && !addr_ld_i;
  assign adv_fault = adv_req && (step_bad || oversize);
  assign mask_ext  = {{(ADDR_W-MASK_W){1'b0}}, mask_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      mask_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (addr_ld_i)                 addr_q <= addr_i;
      else if (adv_req && !adv_fault) addr_q <= addr_next;
      if (mask_ld_i)                 mask_q <= mask_i;
      err_q <= adv_fault;
    end
  end

  assign addr_o     = addr_q;
  assign step_err_o = err_q;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    addr_ld_i |=> (addr_o == $past(addr_i))); // R1

  AST_MASK_TAKEN: assert property (@(posedge clk) disable iff (rst)
    mask_ld_i |=> (mask_q == $past(mask_i))); // R2

  AST_BASE_HELD: assert property (@(posedge clk) disable iff (rst)
    (adv_req && mask_q != '0) |=>
      ((addr_o & ~$past(mask_ext)) == ($past(addr_o) & ~$past(mask_ext)))); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !addr_ld_i) |=> $stable(addr_o)); // R6

  AST_ERR_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    step_err_o |-> (addr_o == $past(addr_o))); // R7

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !adv_req |=> !step_err_o); // R7

  AST_STEP_CODE: assert property (@(posedge clk) disable iff (rst)
    (adv_req && mask_q == '0 && step_i != 2'b11) |=>
      (addr_o == $past(addr_o) + (ADDR_W'(1) << $past(step_i)))); // R3

endmodule

// File: tb/test_circ_addr_gen.sv
module test_circ_addr_gen;

  logic        clk = 1'b0;
  logic        rst;
  logic        addr_ld_i, mask_ld_i, adv_i;
  logic [31:0] addr_i;
  logic [15:0] mask_i;
  logic [1:0]  step_i;
  logic [31:0] addr_o;
  logic        step_err_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  longint exp_addr;
  longint exp_mask;
  bit     exp_err;

  always #4 clk = ~clk;

  circ_addr_gen i_circ_addr_gen (
    .clk(clk), .rst(rst),
    .addr_ld_i(addr_ld_i), .addr_i(addr_i),
    .mask_ld_i(mask_ld_i), .mask_i(mask_i),
    .adv_i(adv_i), .step_i(step_i),
    .addr_o(addr_o), .step_err_o(step_err_o)
  );

  task automatic compare(string tag);
    vectors++;
    if (longint'(addr_o) != exp_addr || step_err_o != exp_err) begin
      miscompares++;
      $display("FAIL %s: addr=%h err=%0d expected addr=%h err=%0d",
               tag, addr_o, step_err_o, exp_addr[31:0], exp_err);
    end
  endtask

  // One clock: drive at negedge, model the edge, compare at next negedge.
  task automatic cyc(bit ld, longint a, bit lm, longint m, bit en,
                     int sc, string tag);
    longint step, size, off, base;
    bit err;
    addr_ld_i = ld; addr_i = a[31:0];
    mask_ld_i = lm; mask_i = m[15:0];
    adv_i = en; step_i = sc[1:0];
    err = 0;
    if (ld) exp_addr = a;
    else if (en) begin
      step = (sc == 0) ? 1 : (sc == 1) ? 2 : 4;
      size = exp_mask + 1;
      if (sc == 3 || (exp_mask != 0 && step > size)) err = 1;
      else if (exp_mask == 0) exp_addr = (exp_addr + step) % 64'h1_0000_0000;
      else begin
        base = exp_addr - (exp_addr % size);
        off  = ((exp_addr % size) + step) % size;
        exp_addr = base + off;
      end
    end
    exp_err = err;
    if (lm) exp_mask = m;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    rst = 1; addr_ld_i = 0; addr_i = '0; mask_ld_i = 0; mask_i = '0;
    adv_i = 0; step_i = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    exp_addr = 0; exp_mask = 0; exp_err = 0;
    compare("R9 reset state");

    // 256-byte buffer, step 4 across the end: F8 FC 00 04, back to back
    cyc(1, 64'h1000_00F8, 1, 64'h00FF, 0, 0, "R1 load");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 2, "R4 R8 wrap step 4");
    // step 1 and step 2 inside a 16-byte buffer
    cyc(1, 64'h0000_A03D, 1, 64'h000F, 0, 0, "R1 load");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 0, "R3 step 1 wrap");
    for (int i = 0; i < 9; i++) cyc(0, 0, 0, 0, 1, 1, "R3 step 2 wrap");
    // idle
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0, "R6 idle hold");
    // load wins over advance
    cyc(1, 64'h0000_5556, 0, 0, 1, 2, "R1 load beats advance");
    // mask change with advance: old mask used (F), new mask 3 after
    cyc(1, 64'h0000_700E, 0, 0, 0, 0, "R1 load");
    cyc(0, 0, 1, 64'h0003, 1, 1, "R2 old mask on same edge");
    cyc(0, 0, 0, 0, 1, 1, "R2 new mask next edge");
    cyc(0, 0, 0, 0, 1, 1, "R2 new mask wraps");
    // full 64 KB field
    cyc(1, 64'h0002_FFFE, 1, 64'hFFFF, 0, 0, "R1 load");
    cyc(0, 0, 0, 0, 1, 1, "R4 64KB wrap keeps bit 16+");
    cyc(0, 0, 0, 0, 1, 2, "R4 64KB step");
    // linear mode across 2^32
    cyc(1, 64'hFFFF_FFFD, 1, 0, 0, 0, "R1 load");
    cyc(0, 0, 0, 0, 1, 0, "R5 linear");
    cyc(0, 0, 0, 0, 1, 1, "R5 linear wrap 2^32");
    cyc(0, 0, 0, 0, 1, 2, "R5 linear step 4");
    cyc(1, 64'h0000_FFFE, 0, 0, 0, 0, "R1 load");
    cyc(0, 0, 0, 0, 1, 1, "R5 carry into bit 16");
    // errors
    cyc(1, 64'h0000_0101, 1, 64'h0001, 0, 0, "R1 load");
    cyc(0, 0, 0, 0, 1, 2, "R7 step larger than buffer");
    cyc(0, 0, 0, 0, 1, 1, "R7 step equals buffer");
    cyc(0, 0, 0, 0, 1, 0, "R7 error clears");
    cyc(0, 0, 0, 0, 1, 3, "R7 undefined code");
    cyc(0, 0, 1, 64'h0000, 1, 3, "R7 undefined code linear");
    cyc(0, 0, 0, 0, 0, 0, "R7 single-cycle flag");
    // reset mid-run
    rst = 1; @(posedge clk); @(negedge clk); rst = 0;
    exp_addr = 0; exp_mask = 0; exp_err = 0;
    compare("R9 reset after use");
    cyc(0, 0, 0, 0, 1, 2, "R9 mask cleared by reset");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule